// File: doc/BRIEF.md
# Open-Drain Port Controller

This block controls a six-pin general-purpose port whose pads can only be pulled low or released. An output latch, loaded from a bus, decides which pins are pulled low. A zero pulls the pin low and a one releases it. The bus can load the whole latch at once or set or clear one bit. A bit operation always starts from the latch contents, so pins that external logic holds low never corrupt the other bits.

Each pin can also be handed to a peripheral. The peripheral's output-enable and value then replace the latch bit for that pin. Pad levels pass through a two-flop synchronizer. The synchronized value is returned on bus reads and is also sent to the peripheral inputs without any gating. A stop-mode request, together with a select bit, releases every pin, including pins under peripheral control.

Top module: `odport_ctrl`

## Requirements
- R1: On reset every latch bit becomes 1, so no pin is pulled low while peripheral control is off.
- R2: A byte write stores `wr_data` in the latch on the next clock edge. From then on, `pull_low[i]` is high exactly when latch bit i is 0, provided the peripheral does not own pin i and stop-mode release is inactive.
- R3: A bit operation (`bit_en`, index `bit_idx`, `bit_val` where 1 sets and 0 clears) changes only latch bit `bit_idx`. It takes effect on the next edge. The other bits keep their latch values whatever the pad levels are.
- R4: When a byte write and a bit operation arrive in the same cycle, only the byte write takes effect.
- R5: A bit operation with `bit_idx` of 6 or 7 leaves the latch unchanged.
- R6: When `periph_oe[i]` is 1, `pull_low[i]` equals the inverse of `periph_out[i]`, whatever latch bit i holds (stop-mode release aside).
- R7: `rd_data` returns the pad levels after a two-flop synchronizer. A pad change made between edges k-1 and k first shows after edge k+1.
- R8: `periph_in` always equals the synchronized pad levels, whatever the latch, enables or stop state.
- R9: While `stop_req` and `stop_sel` are both 1, every `pull_low` bit is 0 in the same cycle.
- R10: While `stop_req` is 1 and `stop_sel` is 0, the pins behave as in normal mode.
- R11: During reset, both synchronizer stages hold all ones, so `rd_data` reads 6'h3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 6 | Byte write value |
| bit_en | input | 1 | Bit set/clear strobe |
| bit_idx | input | 3 | Bit index for set/clear |
| bit_val | input | 1 | 1 sets the bit, 0 clears it |
| rd_data | output | 6 | Synchronized pad levels |
| periph_oe | input | 6 | Per-pin peripheral output-enable |
| periph_out | input | 6 | Per-pin peripheral output value |
| periph_in | output | 6 | Synchronized pad levels to peripherals |
| stop_req | input | 1 | Stop-mode request |
| stop_sel | input | 1 | Release all pins in stop mode when 1 |
| pull_low | output | 6 | Per-pin pull-low driver enable |
| pad_level | input | 6 | Sampled pad levels |

## Verification
The assertions check three things on every cycle: that stop-mode release holds every driver off, that a peripheral-owned pin follows the inverse of its peripheral value, and that a pin follows the value byte-written one cycle earlier. They also check that the read value matches the pad level from two cycles earlier. The bench scenarios cover what per-cycle properties cannot express easily. These are bit operations made while the pads read low, so a wrong read-modify-write base would show up. They also include priority between a byte write and a bit operation in the same cycle, out-of-range bit indices, and the reset value of the synchronizer.

// File: rtl/odport_ctrl.sv
module odport_ctrl #(
  parameter int NPINS = 6,
  parameter int IDXW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NPINS-1:0] wr_data,
  input  logic             bit_en,
  input  logic [IDXW-1:0]  bit_idx,
  input  logic             bit_val,
  output logic [NPINS-1:0] rd_data,
  input  logic [NPINS-1:0] periph_oe,
  input  logic [NPINS-1:0] periph_out,
  output logic [NPINS-1:0] periph_in,
  input  logic             stop_req,
  input  logic             stop_sel,
  output logic [NPINS-1:0] pull_low,
  input  logic [NPINS-1:0] pad_level
);

  logic [NPINS-1:0] latch_q, latch_d;
  logic [NPINS-1:0] sync1_q, sync2_q;
  logic             release_all;

  always_comb begin
    latch_d = latch_q;
    if (wr_en) begin
      latch_d = wr_data;
    end else if (bit_en) begin
      for (int i = 0; i < NPINS; i++) begin
        if (bit_idx == IDXW'(i)) latch_d[i] = bit_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      sync1_q <= '1;
      sync2_q <= '1;
    end else begin
      latch_q <= latch_d;
      sync1_q <= pad_level;
      sync2_q <= sync1_q;
    end
  end

  assign release_all = stop_req & stop_sel;
  assign pull_low    = release_all ? '0 :
                       ((periph_oe & ~periph_out) | (~periph_oe & ~latch_q));
  assign rd_data     = sync2_q;
  assign periph_in   = sync2_q;

endmodule

// File: rtl/odport_ctrl_chk.sv
module odport_ctrl_chk #(
  parameter int NPINS = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [NPINS-1:0] wr_data,
  input logic [NPINS-1:0] periph_oe,
  input logic [NPINS-1:0] periph_out,
  input logic             stop_req,
  input logic             stop_sel,
  input logic [NPINS-1:0] pull_low,
  input logic [NPINS-1:0] pad_level,
  input logic [NPINS-1:0] rd_data
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && stop_sel) |-> (pull_low == '0)); // R9

  AST_PERIPH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_req && stop_sel) |-> ((pull_low & periph_oe) == (~periph_out & periph_oe))); // R6

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(wr_en) && !(stop_req && stop_sel))
      |-> ((pull_low & ~periph_oe) == (~$past(wr_data) & ~periph_oe))); // R2

  AST_READ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (rd_data == $past(pad_level, 2))); // R7

endmodule

bind odport_ctrl odport_ctrl_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .periph_oe(periph_oe), .periph_out(periph_out), .stop_req(stop_req),
  .stop_sel(stop_sel), .pull_low(pull_low), .pad_level(pad_level),
  .rd_data(rd_data)
);

// File: tb/odport_ctrl_tb_top.sv
module odport_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, bit_en = 0, bit_val = 0, stop_req = 0, stop_sel = 0;
  logic [N-1:0] wr_data = '0, periph_oe = '0, periph_out = '0, ext_level = '1;
  logic [2:0] bit_idx = '0;
  logic [N-1:0] rd_data, periph_in, pull_low, pad_level;

  int checks = 0, failures = 0;
  bit auto_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pad_level = ext_level & ~pull_low;

  odport_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bit_en(bit_en), .bit_idx(bit_idx), .bit_val(bit_val), .rd_data(rd_data),
    .periph_oe(periph_oe), .periph_out(periph_out), .periph_in(periph_in),
    .stop_req(stop_req), .stop_sel(stop_sel), .pull_low(pull_low),
    .pad_level(pad_level)
  );

  logic [N-1:0] m_latch, m_s1, m_s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch <= '1; m_s1 <= '1; m_s2 <= '1;
    end else begin
      m_s1 <= pad_level;
      m_s2 <= m_s1;
      if (wr_en) m_latch <= wr_data;
      else if (bit_en && bit_idx < 3'(N)) m_latch[bit_idx] <= bit_val;
    end
  end

  function automatic logic [N-1:0] exp_pull(logic [N-1:0] lat, logic [N-1:0] oe,
                                            logic [N-1:0] po, logic sr, logic ss);
    logic [N-1:0] r;
    if (sr && ss) return '0;
    for (int i = 0; i < N; i++)
      r[i] = oe[i] ? !po[i] : !lat[i];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && auto_on) begin
      logic [N-1:0] e;
      e = exp_pull(m_latch, periph_oe, periph_out, stop_req, stop_sel);
      chk(pull_low === e, "R2 R6 R9 R10 pull_low", pull_low, e);
      chk(rd_data === m_s2, "R7 rd_data", rd_data, m_s2);
      chk(periph_in === m_s2, "R8 periph_in", periph_in, m_s2);
    end
  end

  task automatic idle_inputs();
    wr_en = 0; bit_en = 0;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    ext_level = '0;
    repeat (3) @(negedge clk);
    chk(rd_data === 6'h3F, "R11 reset sync", rd_data, 6'h3F);
    ext_level = '1;
    #1 rst_n = 1;
    step();
    @(negedge clk);
    chk(pull_low === '0, "R1 reset latch", pull_low, '0);
    auto_on = 1;

    // R3: pads held low externally, clear one bit, others must stay released
    ext_level = '0;
    step(); step(); step();
    bit_en = 1; bit_idx = 3'd2; bit_val = 0;
    step(); idle_inputs();
    @(negedge clk);
    chk(pull_low === 6'b000100, "R3 clear single", pull_low, 6'b000100);
    step();
    bit_en = 1; bit_idx = 3'd5; bit_val = 0;
    step(); idle_inputs();
    @(negedge clk);
    chk(pull_low === 6'b100100, "R3 clear second", pull_low, 6'b100100);
    step();
    bit_en = 1; bit_idx = 3'd2; bit_val = 1;
    step(); idle_inputs();
    @(negedge clk);
    chk(pull_low === 6'b100000, "R3 set restores", pull_low, 6'b100000);

    // R4: byte write wins over same-cycle bit op
    step();
    wr_en = 1; wr_data = 6'h3F; bit_en = 1; bit_idx = 3'd0; bit_val = 0;
    step(); idle_inputs();
    @(negedge clk);
    chk(pull_low === '0, "R4 write priority", pull_low, '0);

    // R5: out-of-range index ignored
    step();
    bit_en = 1; bit_idx = 3'd6; bit_val = 0;
    step();
    bit_idx = 3'd7;
    step(); idle_inputs();
    @(negedge clk);
    chk(pull_low === '0, "R5 index 6/7 ignored", pull_low, '0);

    // R7: read lag of two edges
    step();
    ext_level = 6'h2A;
    step();
    @(negedge clk);
    chk(rd_data === '0, "R7 one edge no change", rd_data, '0);
    step();
    @(negedge clk);
    chk(rd_data === 6'h2A, "R7 two edges visible", rd_data, 6'h2A);

    // R9/R10 directed: peripheral pulling low, then stop
    step();
    periph_oe = 6'h01; periph_out = 6'h00; wr_data = 6'h00; wr_en = 1;
    step(); idle_inputs();
    stop_req = 1; stop_sel = 0;
    #1 chk(pull_low === 6'h3F, "R10 stop sel0 normal", pull_low, 6'h3F);
    stop_sel = 1;
    #1 chk(pull_low === '0, "R9 stop sel1 release", pull_low, '0);
    stop_req = 0; stop_sel = 0;

    // random phase
    for (int n = 0; n < 3000; n++) begin
      step();
      wr_en      = ($urandom % 5) == 0;
      wr_data    = N'($urandom);
      bit_en     = ($urandom % 3) == 0;
      bit_idx    = 3'($urandom);
      bit_val    = 1'($urandom);
      periph_oe  = (($urandom % 2) == 0) ? '0 : N'($urandom);
      periph_out = N'($urandom);
      stop_req   = ($urandom % 8) == 0;
      stop_sel   = 1'($urandom);
      ext_level  = (($urandom % 4) == 0) ? '0 : N'($urandom);
    end
    step(); idle_inputs();
    step(); step();
    @(negedge clk);
    auto_on = 0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule